// File: doc/BRIEF.md
# UART Channel Interrupt Prioritiser

This block gathers the interrupt causes of a single UART channel and turns them into one interrupt request line and one encoded cause identifier. Five causes feed it: line status error, receive data available (or trigger level reached), receive timeout, transmit holding register empty, and modem status change. Each cause is gated by one of four enable bits. Only the most urgent enabled pending cause appears in the identifier. Lower causes stay hidden until the more urgent ones have been serviced.

Event causes are latched from one-cycle pulses sent by the FIFO, transmitter and modem logic. They are cleared by the register-decoder strobes that mark the servicing CPU access. The receive data cause is not latched: it follows the FIFO's level-compare output directly. The transmit-empty cause is pending out of reset, so an enabled transmitter interrupts at once. All causes use plain control signals; the block has no data stream and no handshake.

Top module: `uart_irq_prio`

## Requirements
- R1: With no enabled pending cause, `irq_id` is 4'h1 (bit 0 set means nothing pending) and `irq` is 0.
- R2: After reset the transmit-empty cause is pending. With `ier[1]` set, `irq_id` reads 4'h2 and `irq` is 1 without any other stimulus.
- R3: Enable mapping is fixed: `ier[0]` covers receive data and receive timeout, `ier[1]` transmit empty, `ier[2]` line status, `ier[3]` modem status. A disabled cause neither shows in `irq_id` nor raises `irq`. A disabled event cause stays latched and appears as soon as its enable is set.
- R4: Priority from most to least urgent, with its code: line status 4'h6, receive data 4'h4, receive timeout 4'hC, transmit empty 4'h2, modem status 4'h0. `irq_id` shows only the most urgent enabled pending cause.
- R5: A `line_err_evt` pulse makes the line-status cause pending from the next cycle. An `lsr_rd` strobe clears it.
- R6: The receive data cause follows `rx_level_hit` in the same cycle, with no latching.
- R7: An `rx_tmo_evt` pulse makes the timeout cause pending from the next cycle. An `rhr_rd` strobe clears it.
- R8: A `thr_empty_evt` pulse makes transmit empty pending. It clears on `thr_wr`, or on `isr_rd` while 4'h2 is the reported code. An `isr_rd` while another code is reported leaves it pending.
- R9: An `msr_chg_evt` pulse makes the modem cause pending from the next cycle. An `msr_rd` strobe clears it.
- R10: `irq` is 1 exactly when at least one enabled cause is pending.
- R11: When a set pulse and the clear strobe of the same cause arrive in one cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier | input | 4 | Cause enables |
| line_err_evt | input | 1 | Line error detected pulse |
| rx_level_hit | input | 1 | Receive FIFO holds data / reached trigger (level) |
| rx_tmo_evt | input | 1 | Receive timeout expired pulse |
| thr_empty_evt | input | 1 | Transmit holding register became empty pulse |
| msr_chg_evt | input | 1 | Modem input changed pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| isr_rd | input | 1 | Interrupt status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Encoded most-urgent pending cause |

## Verification
A latched cause that is wrongly set or cleared shows up in `irq_id` and `irq` in the cycle after the offending pulse or strobe. This holds only if no more urgent cause is masking it, so the tests retire causes one by one and check each lower code as it surfaces. A wrong priority order shows as a wrong code when two or more causes are pending together. A wrong enable bit shows at once as a mismatch between `irq` and the enables. The reset value of the transmit-empty latch is seen on the first cycle once `ier[1]` is set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  localparam int IDW  = 4;
  // source index: 0 is most urgent
  localparam int S_LINE = 0;
  localparam int S_RXD  = 1;
  localparam int S_TMO  = 2;
  localparam int S_TXE  = 3;
  localparam int S_MDM  = 4;
  localparam logic [IDW-1:0] ID_NONE = 4'h1;
  localparam logic [IDW-1:0] ID_LINE = 4'h6;
  localparam logic [IDW-1:0] ID_RXD  = 4'h4;
  localparam logic [IDW-1:0] ID_TMO  = 4'hC;
  localparam logic [IDW-1:0] ID_TXE  = 4'h2;
  localparam logic [IDW-1:0] ID_MDM  = 4'h0;

  function automatic logic [IDW-1:0] src_code(input int idx);
    case (idx)
      S_LINE:  return ID_LINE;
      S_RXD:   return ID_RXD;
      S_TMO:   return ID_TMO;
      S_TXE:   return ID_TXE;
      default: return ID_MDM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pend_o <= RST_VAL;
    else if (set_i)  pend_o <= 1'b1;   // new event beats a service access
    else if (clr_i)  pend_o <= 1'b0;
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/uart_irq_sel.sv
module uart_irq_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic taken;
  always_comb begin
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant_o[i] = req_i[i] && !taken;
      taken      = taken | req_i[i];
    end
    any_o = taken;
  end

  always_comb begin
    if (!$isunknown(req_i))
      assert_one_grant_R4: assert ($onehot0(grant_o) && ((|grant_o) == (|req_i)));
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     ier,
  input  logic           line_err_evt,
  input  logic           rx_level_hit,
  input  logic           rx_tmo_evt,
  input  logic           thr_empty_evt,
  input  logic           msr_chg_evt,
  input  logic           lsr_rd,
  input  logic           rhr_rd,
  input  logic           isr_rd,
  input  logic           thr_wr,
  input  logic           msr_rd,
  output logic           irq,
  output logic [IDW-1:0] irq_id
);
  logic line_p, tmo_p, txe_p, mdm_p;
  logic [NSRC-1:0] req, grant;
  logic any_req;

  uart_irq_flag #(.RST_VAL(1'b0)) u_line (.clk(clk), .rst_n(rst_n),
    .set_i(line_err_evt), .clr_i(lsr_rd), .pend_o(line_p));
  uart_irq_flag #(.RST_VAL(1'b0)) u_tmo (.clk(clk), .rst_n(rst_n),
    .set_i(rx_tmo_evt), .clr_i(rhr_rd), .pend_o(tmo_p));
  uart_irq_flag #(.RST_VAL(1'b1)) u_txe (.clk(clk), .rst_n(rst_n),
    .set_i(thr_empty_evt), .clr_i(thr_wr | (isr_rd & grant[S_TXE])), .pend_o(txe_p));
  uart_irq_flag #(.RST_VAL(1'b0)) u_mdm (.clk(clk), .rst_n(rst_n),
    .set_i(msr_chg_evt), .clr_i(msr_rd), .pend_o(mdm_p));

  always_comb begin
    req         = '0;
    req[S_LINE] = line_p       & ier[2];
    req[S_RXD]  = rx_level_hit & ier[0];
    req[S_TMO]  = tmo_p        & ier[0];
    req[S_TXE]  = txe_p        & ier[1];
    req[S_MDM]  = mdm_p        & ier[3];
  end

  uart_irq_sel #(.N(NSRC)) u_sel (.req_i(req), .grant_o(grant), .any_o(any_req));

  always_comb begin
    irq_id = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (grant[i]) irq_id = src_code(i);
  end

  assign irq = any_req;

  assert_irq_matches_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_id != ID_NONE));
  assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_p && ier[2]) |-> (irq_id == ID_LINE));
  assert_txe_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && irq_id == ID_TXE && !thr_empty_evt) |=> !txe_p);
  assert_line_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_err_evt) |=> !line_p);
  assert_mdm_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !msr_chg_evt) |=> !mdm_p);
endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ier = 4'h0;
  logic line_err_evt = 0, rx_level_hit = 0, rx_tmo_evt = 0, thr_empty_evt = 0, msr_chg_evt = 0;
  logic lsr_rd = 0, rhr_rd = 0, isr_rd = 0, thr_wr = 0, msr_rd = 0;
  logic irq;
  logic [3:0] irq_id;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_prio u0 (.clk(clk), .rst_n(rst_n), .ier(ier), .line_err_evt(line_err_evt),
    .rx_level_hit(rx_level_hit), .rx_tmo_evt(rx_tmo_evt), .thr_empty_evt(thr_empty_evt),
    .msr_chg_evt(msr_chg_evt), .lsr_rd(lsr_rd), .rhr_rd(rhr_rd), .isr_rd(isr_rd),
    .thr_wr(thr_wr), .msr_rd(msr_rd), .irq(irq), .irq_id(irq_id));

  task automatic expect_out(input string req, input logic [3:0] id, input logic rq);
    #1;
    checks++;
    if (irq_id !== id || irq !== rq) begin
      fails++;
      $display("FAIL %s: irq_id=%h irq=%b expected irq_id=%h irq=%b", req, irq_id, irq, id, rq);
    end
  endtask

  // clear all one-cycle strobes after one clock edge
  task automatic step;
    @(negedge clk);
    line_err_evt = 0; rx_tmo_evt = 0; thr_empty_evt = 0; msr_chg_evt = 0;
    lsr_rd = 0; rhr_rd = 0; isr_rd = 0; thr_wr = 0; msr_rd = 0;
  endtask

  task automatic t_reset;
    expect_out("R1 idle after reset, R3 txe masked", 4'h1, 1'b0);
    ier = 4'h2;
    expect_out("R2 txe pending out of reset", 4'h2, 1'b1);
  endtask

  task automatic t_txe;
    isr_rd = 1; step;
    expect_out("R8 isr read clears reported txe", 4'h1, 1'b0);
    thr_empty_evt = 1; step;
    expect_out("R8 txe set by event", 4'h2, 1'b1);
    thr_wr = 1; step;
    expect_out("R8 thr write clears txe", 4'h1, 1'b0);
  endtask

  task automatic t_masked_txe;
    ier = 4'h6;
    thr_empty_evt = 1; line_err_evt = 1; step;
    expect_out("R4 line beats txe", 4'h6, 1'b1);
    isr_rd = 1; step;
    expect_out("R5 line kept by isr read", 4'h6, 1'b1);
    lsr_rd = 1; step;
    expect_out("R8 txe survives isr read when not reported", 4'h2, 1'b1);
    isr_rd = 1; step;
    expect_out("R8 txe cleared once reported", 4'h1, 1'b0);
  endtask

  task automatic t_rx;
    ier = 4'h1;
    @(negedge clk); rx_level_hit = 1;
    expect_out("R6 rx data follows level same cycle", 4'h4, 1'b1);
    rx_tmo_evt = 1; step;
    expect_out("R4 rx data beats timeout", 4'h4, 1'b1);
    rx_level_hit = 0;
    expect_out("R7 timeout visible after level drops", 4'hC, 1'b1);
    rhr_rd = 1; step;
    expect_out("R7 rhr read clears timeout", 4'h1, 1'b0);
  endtask

  task automatic t_modem_mask;
    ier = 4'h0;
    msr_chg_evt = 1; step;
    expect_out("R3 R10 disabled modem gives no irq", 4'h1, 1'b0);
    ier = 4'h8;
    expect_out("R3 latched modem appears on enable", 4'h0, 1'b1);
    msr_rd = 1; step;
    expect_out("R9 msr read clears modem", 4'h1, 1'b0);
  endtask

  task automatic t_set_wins;
    ier = 4'h4;
    line_err_evt = 1; step;
    line_err_evt = 1; lsr_rd = 1; step;
    expect_out("R11 set beats clear", 4'h6, 1'b1);
    lsr_rd = 1; step;
    expect_out("R5 lsr read clears line", 4'h1, 1'b0);
  endtask

  task automatic t_ladder;
    ier = 4'hF;
    line_err_evt = 1; rx_tmo_evt = 1; thr_empty_evt = 1; msr_chg_evt = 1;
    rx_level_hit = 1; step;
    expect_out("R4 line first", 4'h6, 1'b1);
    lsr_rd = 1; step;
    expect_out("R4 rx data second", 4'h4, 1'b1);
    rx_level_hit = 0;
    expect_out("R4 timeout third", 4'hC, 1'b1);
    rhr_rd = 1; step;
    expect_out("R4 txe fourth", 4'h2, 1'b1);
    thr_wr = 1; step;
    expect_out("R4 modem last", 4'h0, 1'b1);
    ier = 4'h7;
    expect_out("R10 irq drops when only pending cause disabled", 4'h1, 1'b0);
    msr_rd = 1; step;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_txe;
    t_masked_txe;
    t_rx;
    t_modem_mask;
    t_set_wins;
    t_ladder;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule